// File: doc/BRIEF.md
# Dual-Frame Mailbox Channel Windows

This block is a one-way mailbox between two agents. A sender register frame and a receiver register frame each have their own simple memory-mapped port with a word address, a write strobe and a combinational read path. Both frames sit over one shared array of 32-bit channel-window status registers, and a parameter sets how many windows the array has. The sender raises bits in a window's status. The receiver reads the status, decides which bits may interrupt it through a per-window mask, and clears bits once it has consumed them.

The block drives a receiver interrupt whenever any unmasked status bit is set. When the architecture minor revision is at least one, it also provides a sender-side transmit-done interrupt per window, which fires once the receiver has drained a window. Each frame has a bitmap that combines interrupt status across all windows, one bit per window. A frame-level enable gates the bitmap. The sender frame also has an access request/ready handshake and read-only configuration and revision words.

Top module: `mbx_dual_frame`

## Requirements
- R1: After reset, every window status is zero, every mask bit is one, every transmit-done enable and pending flag is zero, access request and ready read zero, and both interrupts are low.
- R2: A sender write to window base + 0x0C ORs the written ones into that window's status (write-1-to-set). Both frames read the status at window base + 0x00. Window n has its base at n*0x20, and the last implemented window behaves the same as the first.
- R3: A receiver write to window base + 0x08 clears the written ones in the status (write-1-to-clear). If a sender set and a receiver clear hit the same bit in the same cycle, the bit ends up set.
- R4: The receiver reads the mask at window base + 0x10. Writing ones to + 0x14 sets mask bits and writing ones to + 0x18 clears them. The masked status at + 0x04 reads status AND NOT mask.
- R5: `rx_irq` is high exactly while some window has a nonzero masked status. It drops right after the clock edge at which the last such bit is cleared or masked.
- R6: On both frames, offset 0xF80 reads the window count in bits [6:0]. On the sender frame, offset 0xFCC reads the minor revision in bits [3:0] and the major revision in bits [7:4].
- R7: Offsets 0xFA0, 0xFA4, 0xFA8 and 0xFAC hold the combined status, with window n at word n/32, bit n%32. The whole group reads zero unless bit 2 of that frame's enable register at 0xF98 is set. A receiver bit means that window's masked status is nonzero. A sender bit means that window's transmit-done flag is pending.
- R8: When the minor revision is at least 1, a window's transmit-done flag sets if a receiver clear takes its status from nonzero to zero while its enable (sender + 0x18 bit 0) is set. The flag reads at sender + 0x10 bit 0, and writing 1 to + 0x14 bit 0 clears it. A clear that leaves bits standing does not set it. `tx_irq` equals the sender bit 2 of 0xF98 AND any pending flag.
- R9: Sender offset 0xF88 bit 0 is the access request, and it can be read and written. Ready at 0xF8C bit 0 follows the request one clock later, so it is never 1 unless request was 1 on the previous cycle.
- R10: Offsets inside an unimplemented window, reserved offsets inside a window, and unused frame offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_wen | input | 1 | Sender frame write strobe |
| s_addr | input | 12 | Sender frame byte address (word aligned) |
| s_wdata | input | 32 | Sender frame write data |
| s_rdata | output | 32 | Sender frame read data, combinational from s_addr |
| r_wen | input | 1 | Receiver frame write strobe |
| r_addr | input | 12 | Receiver frame byte address (word aligned) |
| r_wdata | input | 32 | Receiver frame write data |
| r_rdata | output | 32 | Receiver frame read data, combinational from r_addr |
| rx_irq | output | 1 | Receiver interrupt: some unmasked status bit is set |
| tx_irq | output | 1 | Sender transmit-done interrupt |

## Verification
The set/clear/mask datapath is driven with overlapping bit patterns on one window, so each read separates OR-in from overwrite, clear-of-written-ones from clear-of-all, and masked from raw status. Windows 33 and 39 sit in the second combined word and at the array's edge, and window 45 lies outside the array. Between them they tell correct bitmap position and range gating apart from an off-by-one or wrapped index. Transmit-done is tried with a full drain, a partial drain and a drain with the enable off, which separates "went to zero" from "was written". Same-cycle set and clear on both disjoint and shared bits exposes the wrong priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WIN_MAX    = 124;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int WIN_IDX_W  = 7;
    localparam int COMB_REGS  = 4;
    localparam int COMB_BITS  = COMB_REGS * WORD_W;

    // offsets inside a 0x20-byte window
    localparam logic [4:0] OFS_STAT  = 5'h00;
    localparam logic [4:0] OFS_MSTAT = 5'h04;
    localparam logic [4:0] OFS_CLR   = 5'h08;
    localparam logic [4:0] OFS_SET   = 5'h0C;
    localparam logic [4:0] OFS_ISTAT = 5'h10;
    localparam logic [4:0] OFS_ICLR  = 5'h14;
    localparam logic [4:0] OFS_IEN   = 5'h18;
    localparam logic [4:0] OFS_MASK  = 5'h10;
    localparam logic [4:0] OFS_MSET  = 5'h14;
    localparam logic [4:0] OFS_MCLR  = 5'h18;

    // frame-level words after the window array
    localparam logic [ADDR_W-1:0] FRM_BASE    = 12'hF80;
    localparam logic [ADDR_W-1:0] REG_CFG     = 12'hF80;
    localparam logic [ADDR_W-1:0] REG_ACC_REQ = 12'hF88;
    localparam logic [ADDR_W-1:0] REG_ACC_RDY = 12'hF8C;
    localparam logic [ADDR_W-1:0] REG_FIEN    = 12'hF98;
    localparam logic [ADDR_W-1:0] REG_COMB0   = 12'hFA0;
    localparam logic [ADDR_W-1:0] REG_ARCH    = 12'hFCC;
    localparam int                FIEN_COMB_BIT = 2;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_SET,
        WOP_CLR,
        WOP_MSET,
        WOP_MCLR,
        WOP_IEN,
        WOP_ICLR
    } win_op_e;

    typedef struct packed {
        win_op_e               op;
        logic [WIN_IDX_W-1:0]  win;
        logic [WORD_W-1:0]     data;
    } win_req_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a, input int nwin);
        logic [WIN_IDX_W-1:0] w;
        w = a[ADDR_W-1:5];
        return (a < FRM_BASE) && (int'(w) < nwin);
    endfunction

    function automatic logic [WORD_W-1:0] bit_word(input logic b);
        return {{(WORD_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/mbx_window.sv
module mbx_window
    import mbx_pkg::*;
#(
    parameter int IDX        = 0,
    parameter bit HAS_TXDONE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  win_req_t          s_req,
    input  win_req_t          r_req,
    output logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] mask,
    output logic              ien,
    output logic              pend
);

    logic              s_me;
    logic              r_me;
    logic [WORD_W-1:0] set_bits;
    logic [WORD_W-1:0] clr_bits;
    logic [WORD_W-1:0] stat_nx;
    logic [WORD_W-1:0] mask_nx;

    assign s_me = (s_req.win == WIN_IDX_W'(IDX));
    assign r_me = (r_req.win == WIN_IDX_W'(IDX));

    always_comb begin
        set_bits = (s_me && s_req.op == WOP_SET) ? s_req.data : '0;
        clr_bits = (r_me && r_req.op == WOP_CLR) ? r_req.data : '0;
        // set is applied after clear, so a same-cycle collision leaves the bit set
        stat_nx  = (status & ~clr_bits) | set_bits;
        mask_nx  = mask;
        if (r_me && r_req.op == WOP_MCLR) mask_nx = mask & ~r_req.data;
        if (r_me && r_req.op == WOP_MSET) mask_nx = mask | r_req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= stat_nx;
            mask   <= mask_nx;
        end
    end

    generate
        if (HAS_TXDONE) begin : g_tx
            logic ien_q;
            logic pend_q;
            logic drained;

            assign drained = (clr_bits != '0) && (status != '0) && (stat_nx == '0);

            always_ff @(posedge clk) begin
                if (rst) begin
                    ien_q  <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    if (s_me && s_req.op == WOP_IEN) ien_q <= s_req.data[0];
                    if (drained && ien_q) begin
                        pend_q <= 1'b1;
                    end else if (s_me && s_req.op == WOP_ICLR && s_req.data[0]) begin
                        pend_q <= 1'b0;
                    end
                end
            end

            assign ien  = ien_q;
            assign pend = pend_q;
        end else begin : g_notx
            assign ien  = 1'b0;
            assign pend = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mbx_send_port.sv
module mbx_send_port
    import mbx_pkg::*;
#(
    parameter int NUM_WIN    = 40,
    parameter int MINOR_REV  = 1,
    parameter int MAJOR_REV  = 2,
    parameter bit HAS_TXDONE = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wen,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [WORD_W-1:0]               wdata,
    output logic [WORD_W-1:0]               rdata,
    input  logic [NUM_WIN-1:0][WORD_W-1:0]  status,
    input  logic [NUM_WIN-1:0]              ien,
    input  logic [NUM_WIN-1:0]              pend,
    output win_req_t                        req,
    output logic                            comb_en,
    output logic                            acc_req,
    output logic                            acc_rdy
);

    localparam int LIDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [WIN_IDX_W-1:0] win_a;
    logic [LIDX_W-1:0]    sel;
    logic [4:0]           ofs;
    logic                 hit;
    logic [COMB_BITS-1:0] cmap;
    logic                 comb_en_q;
    logic                 acc_req_q;
    logic                 acc_rdy_q;

    assign win_a = addr[ADDR_W-1:5];
    assign sel   = win_a[LIDX_W-1:0];
    assign ofs   = addr[4:0];
    assign hit   = in_window(addr, NUM_WIN);

    always_comb begin
        req.op   = WOP_NONE;
        req.win  = win_a;
        req.data = wdata;
        if (wen && hit) begin
            case (ofs)
                OFS_SET:  req.op = WOP_SET;
                OFS_IEN:  req.op = HAS_TXDONE ? WOP_IEN  : WOP_NONE;
                OFS_ICLR: req.op = HAS_TXDONE ? WOP_ICLR : WOP_NONE;
                default:  req.op = WOP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_en_q <= 1'b0;
            acc_req_q <= 1'b0;
            acc_rdy_q <= 1'b0;
        end else begin
            acc_rdy_q <= acc_req_q;
            if (wen && addr == REG_ACC_REQ) acc_req_q <= wdata[0];
            if (wen && addr == REG_FIEN)    comb_en_q <= wdata[FIEN_COMB_BIT];
        end
    end

    always_comb begin
        cmap = '0;
        cmap[NUM_WIN-1:0] = pend & {NUM_WIN{comb_en_q}};
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (ofs)
                OFS_STAT:  rdata = status[sel];
                OFS_ISTAT: rdata = bit_word(pend[sel]);
                OFS_IEN:   rdata = bit_word(ien[sel]);
                default:   rdata = '0;
            endcase
        end else begin
            case (addr)
                REG_CFG:     rdata = {25'b0, WIN_IDX_W'(NUM_WIN)};
                REG_ACC_REQ: rdata = bit_word(acc_req_q);
                REG_ACC_RDY: rdata = bit_word(acc_rdy_q);
                REG_FIEN:    rdata = {29'b0, comb_en_q, 2'b0};
                REG_ARCH:    rdata = {24'b0, 4'(MAJOR_REV), 4'(MINOR_REV)};
                default:     rdata = '0;
            endcase
            for (int k = 0; k < COMB_REGS; k++) begin
                if (addr == REG_COMB0 + ADDR_W'(4 * k)) rdata = cmap[k*WORD_W +: WORD_W];
            end
        end
    end

    assign comb_en = comb_en_q;
    assign acc_req = acc_req_q;
    assign acc_rdy = acc_rdy_q;

endmodule

// File: rtl/mbx_recv_port.sv
module mbx_recv_port
    import mbx_pkg::*;
#(
    parameter int NUM_WIN   = 40,
    parameter int MINOR_REV = 1,
    parameter int MAJOR_REV = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wen,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [WORD_W-1:0]               wdata,
    output logic [WORD_W-1:0]               rdata,
    input  logic [NUM_WIN-1:0][WORD_W-1:0]  status,
    input  logic [NUM_WIN-1:0][WORD_W-1:0]  mask,
    input  logic [NUM_WIN-1:0]              live,
    output win_req_t                        req
);

    localparam int LIDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [WIN_IDX_W-1:0] win_a;
    logic [LIDX_W-1:0]    sel;
    logic [4:0]           ofs;
    logic                 hit;
    logic [COMB_BITS-1:0] cmap;
    logic                 comb_en_q;

    assign win_a = addr[ADDR_W-1:5];
    assign sel   = win_a[LIDX_W-1:0];
    assign ofs   = addr[4:0];
    assign hit   = in_window(addr, NUM_WIN);

    always_comb begin
        req.op   = WOP_NONE;
        req.win  = win_a;
        req.data = wdata;
        if (wen && hit) begin
            case (ofs)
                OFS_CLR:  req.op = WOP_CLR;
                OFS_MSET: req.op = WOP_MSET;
                OFS_MCLR: req.op = WOP_MCLR;
                default:  req.op = WOP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_en_q <= 1'b0;
        end else if (wen && addr == REG_FIEN) begin
            comb_en_q <= wdata[FIEN_COMB_BIT];
        end
    end

    always_comb begin
        cmap = '0;
        cmap[NUM_WIN-1:0] = live & {NUM_WIN{comb_en_q}};
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (ofs)
                OFS_STAT:  rdata = status[sel];
                OFS_MSTAT: rdata = status[sel] & ~mask[sel];
                OFS_MASK:  rdata = mask[sel];
                default:   rdata = '0;
            endcase
        end else begin
            case (addr)
                REG_CFG:  rdata = {25'b0, WIN_IDX_W'(NUM_WIN)};
                REG_FIEN: rdata = {29'b0, comb_en_q, 2'b0};
                REG_ARCH: rdata = {24'b0, 4'(MAJOR_REV), 4'(MINOR_REV)};
                default:  rdata = '0;
            endcase
            for (int k = 0; k < COMB_REGS; k++) begin
                if (addr == REG_COMB0 + ADDR_W'(4 * k)) rdata = cmap[k*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/mbx_dual_frame.sv
module mbx_dual_frame
    import mbx_pkg::*;
#(
    parameter int NUM_WIN   = 40,
    parameter int MINOR_REV = 1,
    parameter int MAJOR_REV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_wen,
    input  logic [11:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic [31:0] s_rdata,
    input  logic        r_wen,
    input  logic [11:0] r_addr,
    input  logic [31:0] r_wdata,
    output logic [31:0] r_rdata,
    output logic        rx_irq,
    output logic        tx_irq
);

    localparam bit HAS_TXDONE = (MINOR_REV >= 1);

    logic [NUM_WIN-1:0][WORD_W-1:0] win_stat;
    logic [NUM_WIN-1:0][WORD_W-1:0] win_mask;
    logic [NUM_WIN-1:0]             win_ien;
    logic [NUM_WIN-1:0]             win_pend;
    logic [NUM_WIN-1:0]             win_live;
    win_req_t                       s_req;
    win_req_t                       r_req;
    logic                           s_comb_en;
    logic                           acc_req;
    logic                           acc_rdy;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            mbx_window #(
                .IDX        (gi),
                .HAS_TXDONE (HAS_TXDONE)
            ) i_win (
                .clk    (clk),
                .rst    (rst),
                .s_req  (s_req),
                .r_req  (r_req),
                .status (win_stat[gi]),
                .mask   (win_mask[gi]),
                .ien    (win_ien[gi]),
                .pend   (win_pend[gi])
            );
            assign win_live[gi] = |(win_stat[gi] & ~win_mask[gi]);
        end
    endgenerate

    mbx_send_port #(
        .NUM_WIN    (NUM_WIN),
        .MINOR_REV  (MINOR_REV),
        .MAJOR_REV  (MAJOR_REV),
        .HAS_TXDONE (HAS_TXDONE)
    ) i_send (
        .clk     (clk),
        .rst     (rst),
        .wen     (s_wen),
        .addr    (s_addr),
        .wdata   (s_wdata),
        .rdata   (s_rdata),
        .status  (win_stat),
        .ien     (win_ien),
        .pend    (win_pend),
        .req     (s_req),
        .comb_en (s_comb_en),
        .acc_req (acc_req),
        .acc_rdy (acc_rdy)
    );

    mbx_recv_port #(
        .NUM_WIN   (NUM_WIN),
        .MINOR_REV (MINOR_REV),
        .MAJOR_REV (MAJOR_REV)
    ) i_recv (
        .clk    (clk),
        .rst    (rst),
        .wen    (r_wen),
        .addr   (r_addr),
        .wdata  (r_wdata),
        .rdata  (r_rdata),
        .status (win_stat),
        .mask   (win_mask),
        .live   (win_live),
        .req    (r_req)
    );

    assign rx_irq = |win_live;

    generate
        if (HAS_TXDONE) begin : g_txirq
            assign tx_irq = s_comb_en & (|win_pend);
        end else begin : g_notxirq
            assign tx_irq = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mbx_dual_frame_chk.sv
module mbx_dual_frame_chk #(
    parameter int NUM_WIN = 40
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         rx_irq,
    input logic                         tx_irq,
    input logic                         s_wen,
    input logic [11:0]                  s_addr,
    input logic [31:0]                  s_wdata,
    input logic [NUM_WIN-1:0][31:0]     win_stat,
    input logic [NUM_WIN-1:0][31:0]     win_mask,
    input logic [NUM_WIN-1:0]           win_ien,
    input logic [NUM_WIN-1:0]           win_pend,
    input logic                         acc_req,
    input logic                         acc_rdy
);

    p_irq_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!rx_irq && !tx_irq));

    p_rx_needs_status_r5: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (win_stat != '0));

    p_tx_needs_pend_r8: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> (win_pend != '0));

    p_ready_follows_request_r9: assert property (@(posedge clk) disable iff (rst)
        acc_rdy |-> $past(acc_req));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_chk
            p_mask_ones_after_reset_r1: assert property (@(posedge clk)
                rst |=> (win_mask[gi] == '1));

            p_set_bits_land_r3: assert property (@(posedge clk) disable iff (rst)
                (s_wen && s_addr == 12'(gi * 32 + 12)) |=>
                    ((win_stat[gi] & $past(s_wdata)) == $past(s_wdata)));

            p_txdone_cause_r8: assert property (@(posedge clk) disable iff (rst)
                $rose(win_pend[gi]) |->
                    ($past(win_stat[gi]) != '0 && win_stat[gi] == '0 && $past(win_ien[gi])));
        end
    endgenerate

endmodule

bind mbx_dual_frame mbx_dual_frame_chk #(.NUM_WIN(NUM_WIN)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq),
    .s_wen    (s_wen),
    .s_addr   (s_addr),
    .s_wdata  (s_wdata),
    .win_stat (win_stat),
    .win_mask (win_mask),
    .win_ien  (win_ien),
    .win_pend (win_pend),
    .acc_req  (acc_req),
    .acc_rdy  (acc_rdy)
);

// File: tb/test_mbx_dual_frame.sv
module test_mbx_dual_frame;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_wen = 1'b0;
    logic [11:0] s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        r_wen = 1'b0;
    logic [11:0] r_addr = '0;
    logic [31:0] r_wdata = '0;
    logic [31:0] r_rdata;
    logic        rx_irq;
    logic        tx_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbx_dual_frame #(.NUM_WIN(NW), .MINOR_REV(1), .MAJOR_REV(2)) i_mbx_dual_frame (
        .clk     (clk),
        .rst     (rst),
        .s_wen   (s_wen),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_rdata (s_rdata),
        .r_wen   (r_wen),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata),
        .rx_irq  (rx_irq),
        .tx_irq  (tx_irq)
    );

    // frm: 0 sender, 1 receiver; wr: 1 write, 0 read-and-compare
    typedef struct packed {
        logic        frm;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 12'hF80, 32'h0000_0028, 8'd6},   // R6 window count, receiver
        '{1'b0, 1'b0, 12'hF80, 32'h0000_0028, 8'd6},   // R6 window count, sender
        '{1'b0, 1'b0, 12'hFCC, 32'h0000_0021, 8'd6},   // R6 revision word
        '{1'b0, 1'b1, 12'h00C, 32'h0000_00A5, 8'd2},   // R2 set
        '{1'b1, 1'b0, 12'h000, 32'h0000_00A5, 8'd2},   // R2 receiver sees it
        '{1'b0, 1'b0, 12'h000, 32'h0000_00A5, 8'd2},   // R2 sender sees it
        '{1'b1, 1'b0, 12'h004, 32'h0000_0000, 8'd4},   // R4 fully masked
        '{1'b1, 1'b1, 12'h018, 32'h0000_000F, 8'd4},   // R4 mask clear
        '{1'b1, 1'b0, 12'h010, 32'hFFFF_FFF0, 8'd4},   // R4 mask read
        '{1'b1, 1'b0, 12'h004, 32'h0000_0005, 8'd4},   // R4 masked status
        '{1'b0, 1'b1, 12'h00C, 32'h0000_0100, 8'd2},   // R2 OR-in
        '{1'b0, 1'b0, 12'h000, 32'h0000_01A5, 8'd2},   // R2
        '{1'b1, 1'b1, 12'h008, 32'h0000_0081, 8'd3},   // R3 clear
        '{1'b1, 1'b0, 12'h000, 32'h0000_0124, 8'd3},   // R3
        '{1'b1, 1'b1, 12'h014, 32'h0000_0004, 8'd4},   // R4 mask set
        '{1'b1, 1'b0, 12'h004, 32'h0000_0000, 8'd4},   // R4
        '{1'b0, 1'b1, 12'h5AC, 32'h0000_0001, 8'd10},  // R10 window 45 absent
        '{1'b0, 1'b0, 12'h5A0, 32'h0000_0000, 8'd10},  // R10
        '{1'b1, 1'b0, 12'h00C, 32'h0000_0000, 8'd10},  // R10 reserved in-window
        '{1'b0, 1'b1, 12'hF98, 32'h0000_0004, 8'd7},   // R7 frame enable
        '{1'b0, 1'b0, 12'hF98, 32'h0000_0004, 8'd7},   // R7
        '{1'b1, 1'b0, 12'hFC0, 32'h0000_0000, 8'd10},  // R10 unused frame word
        '{1'b0, 1'b1, 12'hFC0, 32'h0000_0005, 8'd10},  // R10 write ignored
        '{1'b0, 1'b0, 12'hFC0, 32'h0000_0000, 8'd10},  // R10
        '{1'b0, 1'b1, 12'h4EC, 32'h0000_0001, 8'd2},   // R2 last window 39
        '{1'b1, 1'b0, 12'h4E0, 32'h0000_0001, 8'd2}    // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic frm, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        if (frm) begin r_wen = 1'b1; r_addr = a; r_wdata = d; end
        else     begin s_wen = 1'b1; s_addr = a; s_wdata = d; end
        @(negedge clk);
        s_wen = 1'b0;
        r_wen = 1'b0;
    endtask

    task automatic wr_both(input logic [11:0] sa, input logic [31:0] sd,
                           input logic [11:0] ra, input logic [31:0] rd);
        @(negedge clk);
        s_wen = 1'b1; s_addr = sa; s_wdata = sd;
        r_wen = 1'b1; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        s_wen = 1'b0;
        r_wen = 1'b0;
    endtask

    task automatic rd(input logic frm, input logic [11:0] a, output logic [31:0] v);
        if (frm) r_addr = a; else s_addr = a;
        #1;
        v = frm ? r_rdata : s_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic frm, input logic [11:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(frm, a, v);
        check(tag, v, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        check("R1 rx_irq", {31'b0, rx_irq}, 32'h0);
        check("R1 tx_irq", {31'b0, tx_irq}, 32'h0);
        rd_chk("R1 mask", 1'b1, 12'h070, 32'hFFFF_FFFF);
        rd_chk("R1 status", 1'b0, 12'h060, 32'h0);
        rd_chk("R1 ien", 1'b0, 12'h078, 32'h0);
        rd_chk("R1 acc req", 1'b0, 12'hF88, 32'h0);
        rd_chk("R1 acc rdy", 1'b0, 12'hF8C, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].frm, VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].frm, VECS[i].addr, v);
                n_checks++;
                if (v !== VECS[i].data) begin
                    n_fails++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VECS[i].req, i, v, VECS[i].data);
                end
            end
        end

        do_reset();

        // R5 / R7 on window 33 (base 0x420), second combined word
        wr(1'b0, 12'h42C, 32'h8);
        check("R5 masked no irq", {31'b0, rx_irq}, 32'h0);
        wr(1'b1, 12'h438, 32'h8);
        check("R5 irq on unmask", {31'b0, rx_irq}, 32'h1);
        rd_chk("R7 gated off", 1'b1, 12'hFA4, 32'h0);
        wr(1'b1, 12'hF98, 32'h4);
        rd_chk("R7 rx word1", 1'b1, 12'hFA4, 32'h0000_0002);
        rd_chk("R7 rx word0", 1'b1, 12'hFA0, 32'h0);

        // R8 full drain with enable
        wr(1'b0, 12'h438, 32'h1);
        wr(1'b0, 12'hF98, 32'h4);
        check("R8 no early tx", {31'b0, tx_irq}, 32'h0);
        wr(1'b1, 12'h428, 32'h8);
        check("R5 irq drops", {31'b0, rx_irq}, 32'h0);
        rd_chk("R8 pending", 1'b0, 12'h430, 32'h1);
        check("R8 tx_irq", {31'b0, tx_irq}, 32'h1);
        rd_chk("R7 tx word1", 1'b0, 12'hFA4, 32'h0000_0002);
        wr(1'b0, 12'h434, 32'h1);
        rd_chk("R8 pend cleared", 1'b0, 12'h430, 32'h0);
        check("R8 tx_irq low", {31'b0, tx_irq}, 32'h0);

        // R8 partial drain on window 2 (base 0x040)
        wr(1'b0, 12'h04C, 32'h3);
        wr(1'b0, 12'h058, 32'h1);
        wr(1'b1, 12'h048, 32'h1);
        rd_chk("R8 partial no pend", 1'b0, 12'h050, 32'h0);
        wr(1'b1, 12'h048, 32'h2);
        rd_chk("R8 drain pend", 1'b0, 12'h050, 32'h1);
        wr(1'b0, 12'h054, 32'h1);

        // R8 drain with enable off, window 3 (base 0x060)
        wr(1'b0, 12'h06C, 32'h1);
        wr(1'b1, 12'h068, 32'h1);
        rd_chk("R8 disabled no pend", 1'b0, 12'h070, 32'h0);
        check("R8 tx_irq quiet", {31'b0, tx_irq}, 32'h0);

        // R3 same-cycle set and clear, window 5 (base 0x0A0)
        wr(1'b0, 12'h0AC, 32'h10);
        wr_both(12'h0AC, 32'h1, 12'h0A8, 32'h11);
        rd_chk("R3 collide", 1'b1, 12'h0A0, 32'h1);
        wr_both(12'h0AC, 32'h1, 12'h0A8, 32'h1);
        rd_chk("R3 same bit set wins", 1'b1, 12'h0A0, 32'h1);

        // R9 access handshake
        wr(1'b0, 12'hF88, 32'h1);
        rd_chk("R9 req", 1'b0, 12'hF88, 32'h1);
        rd_chk("R9 rdy lag", 1'b0, 12'hF8C, 32'h0);
        @(negedge clk);
        rd_chk("R9 rdy", 1'b0, 12'hF8C, 32'h1);
        wr(1'b0, 12'hF88, 32'h0);
        @(negedge clk);
        rd_chk("R9 rdy drop", 1'b0, 12'hF8C, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule